// File: doc/BRIEF.md
# Peripheral Interrupt Controller with Deferred Arming

This block is the interrupt side of a bus peripheral that sits on an 8-bit, active-low strobed processor bus. The system clock samples the bus strobes. The CPU programs the block with I/O write cycles. A control word can load the interrupt vector, or it can request a change to the interrupt enable. An enable change is not applied when it is written. It is held as pending and takes effect at the next falling edge of the opcode-fetch strobe. Any reconfiguration therefore completes at an instruction boundary.

An internal event input is latched. When the latched event and the armed enable are both set, the block pulls its active-low request line low. The CPU then runs an acknowledge cycle, in which the fetch strobe and the I/O strobe are low together. During that cycle the block drives its stored vector onto the data bus. When the acknowledge cycle ends, the latched event is cleared and the request is released.

A small bus-cycle state machine tracks the strobes. It has three states. BUS_IDLE means no cycle is in progress. BUS_IOWR means an I/O write is in progress. BUS_INTA means an acknowledge cycle is in progress. The transitions are:
- BUS_IDLE to BUS_IOWR when a write begins.
- BUS_IDLE to BUS_INTA when an acknowledge begins.
- BUS_IOWR to BUS_IDLE when the write strobe ends. This transition commits the written byte.
- BUS_IOWR to BUS_INTA when the fetch strobe drops during the write. The write is then abandoned and nothing is committed.
- BUS_INTA to BUS_IDLE when the acknowledge ends. This transition clears the event.

Top module: `irq_arm_ctrl`

## Requirements
- R1: After the asynchronous reset, `int_n` is 1, `data_oe` is 0, the enable is off, nothing is pending, and the vector is 0x00.
- R2: A cycle with `iorq_n`=0, `wr_n`=0 and `m1_n`=1 is an I/O write. The byte sampled in the last clock of the cycle with both strobes low is committed in the first clock after the strobes end.
- R3: A committed byte with bit 0 equal to 0 replaces all 8 bits of the vector.
- R4: A committed byte whose bits 3..0 are 0111 makes bit 7 the pending enable value. The armed enable keeps its old value until the first clock in which `m1_n` is sampled low after having been sampled high.
- R5: A committed byte with bit 0 equal to 1 and bits 3..0 not equal to 0111 changes neither the vector nor the enable.
- R6: Several control writes before the arming edge leave only the last written enable value to be applied.
- R7: When `m1_n` and `iorq_n` are low together, the cycle is an acknowledge. It is never taken as a write, even when `wr_n` is low.
- R8: A high `evt` is latched whether or not the enable is armed. `int_n` is 0 exactly when the enable is armed and the event latch is set.
- R9: `data_oe` is 1 only while `m1_n`=0, `iorq_n`=0 and `int_n`=0. While `data_oe` is 1, `data_out` carries the vector. Otherwise `data_out` is 0.
- R10: The first clock after an acknowledge cycle ends clears the event latch, which releases `int_n`. An `evt` in that same clock sets the latch again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low (observed only) |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low (observed only) |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | DATA_W | Data bus as driven by the CPU |
| evt | input | 1 | Internal interrupt event, active high |
| int_n | output | 1 | Interrupt request, active low |
| data_out | output | DATA_W | Vector byte for the data bus |
| data_oe | output | 1 | Data bus drive enable for the vector |

## Verification
The bench builds the block with the default DATA_W of 8. Every control-word format is then a real byte: even vector bytes, control bytes with either enable value, and odd bytes that do not match the control nibble. This lets random traffic mix vector loads, enable changes, ignored words, fetches, events and acknowledges, all checked against a bench model. With this width, the directed cases can also reach:
- a disable that overrides a still-pending enable,
- a write attempted while the fetch strobe is low,
- an event raised in the same clock the acknowledge ends.

// File: rtl/irq_arm_pkg.sv
package irq_arm_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_IOWR = 2'd1,
        BUS_INTA = 2'd2
    } bus_st_e;

    localparam logic [3:0] CTRL_NIBBLE = 4'b0111;
endpackage

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_arm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m1_n,
    input  logic              iorq_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    output logic              wr_commit,
    output logic [DATA_W-1:0] wr_byte,
    output logic              ack_end,
    output logic              m1_fall
);
    bus_st_e state_q, state_d;
    logic    m1_q;
    logic    wr_cond, ack_cond;

    assign wr_cond  = !iorq_n && !wr_n && m1_n;
    assign ack_cond = !iorq_n && !m1_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (ack_cond)     state_d = BUS_INTA;
                else if (wr_cond) state_d = BUS_IOWR;
            end
            BUS_IOWR: begin
                if (ack_cond)      state_d = BUS_INTA;
                else if (!wr_cond) state_d = BUS_IDLE;
            end
            BUS_INTA: begin
                if (!ack_cond) state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_commit = 1'b0;
        ack_end   = 1'b0;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_IOWR: wr_commit = !wr_cond && !ack_cond;
            BUS_INTA: ack_end   = !ack_cond;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1_q    <= 1'b1;
            wr_byte <= '0;
        end else begin
            m1_q <= m1_n;
            if (wr_cond) wr_byte <= din;
        end
    end

    assign m1_fall = m1_q && !m1_n;

    // R7: an acknowledge never leads to a commit on the next clock
    a_r7_no_commit_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_cond |=> !wr_commit || $past(wr_cond));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_arm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              m1_fall,
    output logic [DATA_W-1:0] vector,
    output logic              armed
);
    localparam int EN_BIT = DATA_W - 1;

    logic pend_q, pend_val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vector     <= '0;
            armed      <= 1'b0;
            pend_q     <= 1'b0;
            pend_val_q <= 1'b0;
        end else begin
            if (m1_fall && pend_q) begin
                armed  <= pend_val_q;
                pend_q <= 1'b0;
            end
            if (wr_commit) begin
                if (!wr_byte[0]) begin
                    vector <= wr_byte;
                end else if (wr_byte[3:0] == CTRL_NIBBLE) begin
                    pend_q     <= 1'b1;
                    pend_val_q <= wr_byte[EN_BIT];
                end
            end
        end
    end

    // R4: the armed enable only moves on an M1 falling edge
    a_r4_arm_on_m1_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (armed != $past(armed)) |-> $past(m1_fall));
    // R3: the vector only moves on a committed write
    a_r3_vector_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (vector != $past(vector)) |-> $past(wr_commit));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack_end,
    input  logic armed,
    output logic int_n
);
    logic ev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= 1'b0;
        end else if (evt) begin
            ev_q <= 1'b1;
        end else if (ack_end) begin
            ev_q <= 1'b0;
        end
    end

    assign int_n = !(armed && ev_q);

    // R10: an ended acknowledge leaves the latch clear unless a new event came
    a_r10_clear_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_end |=> !ev_q || $past(evt));
endmodule

// File: rtl/irq_arm_ctrl.sv
module irq_arm_ctrl
    import irq_arm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m1_n,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              evt,
    output logic              int_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    logic              wr_commit, ack_end, m1_fall, armed;
    logic [DATA_W-1:0] wr_byte, vector;
    logic              unused_strobes;

    assign unused_strobes = mreq_n ^ rd_n;

    irq_bus_fsm #(.DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .iorq_n(iorq_n), .wr_n(wr_n),
        .din(data_in), .wr_commit(wr_commit), .wr_byte(wr_byte),
        .ack_end(ack_end), .m1_fall(m1_fall)
    );

    irq_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_byte(wr_byte),
        .m1_fall(m1_fall), .vector(vector), .armed(armed)
    );

    irq_req_latch u_req (
        .clk(clk), .rst_n(rst_n), .evt(evt), .ack_end(ack_end),
        .armed(armed), .int_n(int_n)
    );

    assign data_oe  = !m1_n && !iorq_n && !int_n;
    assign data_out = data_oe ? vector : '0;

    // R9: bus driven only inside an acknowledge with a live request
    a_r9_oe_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!m1_n && !iorq_n && !int_n));
    // R8: a request needs the enable to be armed
    a_r8_req_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> armed);
    // R9: released bus carries zero
    a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));
endmodule

// File: tb/irq_arm_ctrl_tb.sv
module irq_arm_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic evt = 1'b0;
    logic int_n, data_oe;
    logic [DW-1:0] data_out;

    int checks = 0, fails = 0;

    // bench model
    logic m_ena, m_pend, m_pval, m_ev;
    logic [7:0] m_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arm_ctrl #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .evt(evt),
        .int_n(int_n), .data_out(data_out), .data_oe(data_oe)
    );

    function automatic logic exp_int_n();
        return !(m_ena && m_ev);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(int_n == exp_int_n(), req, int_n, exp_int_n());
        chk(data_oe == 1'b0, req, data_oe, 0);
    endtask

    function automatic void model_commit(input logic [7:0] b);
        if (!b[0]) m_vec = b;
        else if (b[3:0] == 4'b0111) begin
            m_pend = 1'b1;
            m_pval = b[7];
        end
    endfunction

    function automatic void model_m1_fall();
        if (m_pend) begin
            m_ena  = m_pval;
            m_pend = 1'b0;
        end
    endfunction

    task automatic io_write(input logic [7:0] b);
        iorq_n = 1'b0; wr_n = 1'b0; data_in = b;
        @(negedge clk);
        iorq_n = 1'b1; wr_n = 1'b1; data_in = 8'hA5;
        @(negedge clk);
        model_commit(b);
    endtask

    task automatic fetch();
        m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        model_m1_fall();
        m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic raise_evt();
        evt = 1'b1;
        @(negedge clk);
        evt = 1'b0;
        m_ev = 1'b1;
    endtask

    // acknowledge; optional write strobe low (R7) and event at end (R10)
    task automatic ack(input logic with_wr, input logic evt_at_end, input string req);
        logic live;
        live = m_ena && m_ev;
        m1_n = 1'b0; iorq_n = 1'b0; wr_n = !with_wr; data_in = 8'h3C;
        #1;
        chk(data_oe == live, req, data_oe, live);
        chk(data_out == (live ? m_vec : 8'h00), req, data_out, live ? m_vec : 8'h00);
        @(negedge clk);
        model_m1_fall();
        m1_n = 1'b1; iorq_n = 1'b1; wr_n = 1'b1; evt = evt_at_end;
        @(negedge clk);
        evt = 1'b0;
        m_ev = evt_at_end;
    endtask

    // makes vector observable: arms enable, raises event, acks
    task automatic observe_vec(input string req);
        io_write(8'h87); fetch(); raise_evt();
        ack(1'b0, 1'b0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ena = 0; m_pend = 0; m_pval = 0; m_ev = 0; m_vec = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(int_n == 1'b1, "R1", int_n, 1);
        chk(data_oe == 1'b0, "R1", data_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        raise_evt();
        chk_idle("R1");
        // R8: event held while disabled, R4 arming deferred
        io_write(8'h87);
        chk(int_n == 1'b1, "R4 deferred", int_n, 1);
        chk_idle("R8");
        fetch();
        chk(int_n == 1'b0, "R4 armed after M1", int_n, 0);
        // R3 vector load, R9 ack drives vector (before R3 load vector is 0)
        io_write(8'h42);
        chk_idle("R3");
        ack(1'b0, 1'b0, "R9 vector");
        chk(int_n == 1'b1, "R10 release", int_n, 1);
        // R5 junk words
        io_write(8'h81); io_write(8'hF5); io_write(8'h0F);
        fetch();
        raise_evt();
        chk(int_n == 1'b0, "R5", int_n, 0);
        ack(1'b0, 1'b0, "R5 vector kept");
        // R6 last write wins
        io_write(8'h07); io_write(8'h87); io_write(8'h07);
        fetch();
        raise_evt();
        chk(int_n == 1'b1, "R6", int_n, 1);
        // R7 write strobe during acknowledge ignored
        io_write(8'h87); fetch();
        ack(1'b1, 1'b0, "R7");
        raise_evt();
        ack(1'b0, 1'b0, "R7 vector kept");
        // R10 event in ack end clock re-latches
        raise_evt();
        ack(1'b0, 1'b1, "R10");
        chk(int_n == 1'b0, "R10 relatched", int_n, 0);
        ack(1'b0, 1'b0, "R10");
        // R2: data value from last low clock
        iorq_n = 1'b0; wr_n = 1'b0; data_in = 8'h10;
        @(negedge clk); data_in = 8'h2E;
        @(negedge clk); iorq_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        model_commit(8'h2E);
        observe_vec("R2");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] b;
            op = int'($urandom % 6);
            b = 8'($urandom);
            case (op)
                0: io_write({b[7:1], 1'b0});
                1: io_write({b[7], b[6:4], 4'b0111});
                2: io_write((b[3:0] == 4'b0111) ? (b | 8'h09) : (b | 8'h01));
                3: fetch();
                4: raise_evt();
                default: ack(b[0] & b[1], b[2] & b[3], "R9 random");
            endcase
            chk_idle("R8 random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule